// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block produces the word addresses for a synchronous burst read from a memory array. A start strobe loads the first address of the burst. After that the block steps the address by one word on every beat that the consumer accepts. A stop input ends the burst. A small configuration register selects how the address steps. In continuous mode it counts straight through the whole array and rolls over from the top address to zero. In one of three wrap modes it stays inside an aligned window of 8, 16 or 32 words. In a wrap mode it climbs to the top of the window, drops back to the window's first word and continues up to the word where the burst began.

The burst takes its stepping mode from the configuration register at the moment it starts. A configuration write during a burst therefore only affects later bursts. The beat-advance input allows stalls of any length. A fresh start strobe restarts the sequence at any time, whether a burst is running, stalled or stopped.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `valid` is low, `addr` is zero and the configured mode is continuous (code 00).
- R2: The 2-bit mode code written through `cfg_we`/`cfg_mode` selects 00 = continuous, 01 = 8-word wrap, 10 = 16-word wrap, 11 = 32-word wrap.
- R3: In continuous mode each accepted beat adds one to `addr`. The address after 2^AW-1 is 0.
- R4: In an N-word wrap mode each accepted beat adds one to the address modulo N within the aligned N-word window that holds the start address. After the window's last word comes its first word, and the sequence runs on through the start word.
- R5: In a wrap mode, address bits above log2(N) do not change during the burst.
- R6: While a burst is active and `advance` is low (and neither `start` nor `stop` is high), `addr` holds its value.
- R7: `start` loads `start_addr` into `addr` and raises `valid` on the next clock edge, whatever the current state. A burst running at that time is abandoned.
- R8: `stop` (without `start`) clears `valid` on the next edge and leaves `addr` unchanged. While `valid` is low, `advance` has no effect on `addr`.
- R9: The mode is captured at `start`. A configuration write during a burst does not change that burst's sequence and applies to the next burst.
- R10: When `start` and `stop` are high in the same cycle, `start` wins: the burst begins at `start_addr` with `valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode configuration register |
| cfg_mode | input | 2 | Mode code to write (00/01/10/11 as in R2) |
| start | input | 1 | Begin a burst at `start_addr` |
| start_addr | input | AW | First word address of the burst |
| advance | input | 1 | A beat was accepted; step the address |
| stop | input | 1 | End the current burst |
| addr | output | AW | Current word address |
| valid | output | 1 | A burst is active and `addr` is meaningful |

## Verification
The bench builds the block with an 8-bit address and sweeps every start address under all four modes. Each burst runs beyond one full window, with and without stalls. This exposes a window base computed from the wrong bit, a carry that leaks into the upper bits in wrap mode, and a continuous counter that fails to roll over from 255 to 0. Directed cases go after the edges between control inputs. A restart in the middle of a burst must not continue the old sequence. A stop must freeze the address rather than clear it, and later beats must not move it. A start arriving together with a stop must win. A mode write during a burst must not bend that burst's wrap, which would show up as a jump to the next window.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [1:0] {
        MODE_LINEAR = 2'b00,
        MODE_WRAP8  = 2'b01,
        MODE_WRAP16 = 2'b10,
        MODE_WRAP32 = 2'b11
    } burst_mode_e;

    // log2 of the wrap window for the smallest wrap mode; later modes double it
    localparam int WIN_LOG_MIN = 3;
    localparam int WIN_COUNT   = 3;

endpackage

// File: rtl/bas_cfg_reg.sv
module bas_cfg_reg
    import bas_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  wdata,
    output burst_mode_e mode
);

    burst_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d = burst_mode_e'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_LINEAR;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R1
    reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == MODE_LINEAR));

    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mode_q == burst_mode_e'($past(wdata))));

endmodule

// File: rtl/bas_addr_step.sv
module bas_addr_step
    import bas_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic [AW-1:0] addr_i,
    input  burst_mode_e   mode_i,
    output logic [AW-1:0] next_o
);

    logic [AW-1:0] lin_next;
    logic [AW-1:0] wrap_next [WIN_COUNT];

    assign lin_next = addr_i + AW'(1);

    for (genvar gi = 0; gi < WIN_COUNT; gi++) begin : g_win
        localparam int LOG = WIN_LOG_MIN + gi;
        logic [LOG-1:0] low_inc;
        assign low_inc       = addr_i[LOG-1:0] + LOG'(1);
        assign wrap_next[gi] = {addr_i[AW-1:LOG], low_inc};
    end

    always_comb begin
        unique case (mode_i)
            MODE_WRAP8:  next_o = wrap_next[0];
            MODE_WRAP16: next_o = wrap_next[1];
            MODE_WRAP32: next_o = wrap_next[2];
            default:     next_o = lin_next;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          advance,
    input  logic          stop,
    output logic [AW-1:0] addr,
    output logic          valid
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          valid;
        burst_mode_e   mode;
    } seq_state_t;

    seq_state_t  st_d, st_q;
    burst_mode_e cfg_mode_q;
    logic [AW-1:0] step_next;

    bas_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_mode),
        .mode  (cfg_mode_q)
    );

    bas_addr_step #(.AW(AW)) u_step (
        .addr_i (st_q.addr),
        .mode_i (st_q.mode),
        .next_o (step_next)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.addr  = start_addr;
            st_d.valid = 1'b1;
            st_d.mode  = cfg_mode_q;
        end else if (stop) begin
            st_d.valid = 1'b0;
        end else if (st_q.valid && advance) begin
            st_d.addr = step_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, valid: 1'b0, mode: MODE_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr  = st_q.addr;
    assign valid = st_q.valid;

    logic beat_q;
    assign beat_q = st_q.valid && advance && !start && !stop;

    // R7
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && addr == $past(start_addr)));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> (!valid && $stable(addr)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !start) |=> (!valid && $stable(addr)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !advance && !start && !stop) |=> $stable(addr));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_q && st_q.mode == MODE_LINEAR) |=> (addr == $past(addr) + AW'(1)));

    for (genvar gw = 0; gw < WIN_COUNT; gw++) begin : g_win_chk
        localparam int LOG = WIN_LOG_MIN + gw;
        localparam burst_mode_e WMODE = burst_mode_e'(gw + 1);
        // R5
        window_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_q && st_q.mode == WMODE) |=> (addr[AW-1:LOG] == $past(addr[AW-1:LOG])));
    end

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW   = 8;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          advance = 1'b0;
    logic          stop = 1'b0;
    logic [AW-1:0] addr;
    logic          valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .start      (start),
        .start_addr (start_addr),
        .advance    (advance),
        .stop       (stop),
        .addr       (addr),
        .valid      (valid)
    );

    function automatic int exp_addr(int m, int s, int k);
        int n    = (m == 0) ? SPAN : (4 << m);
        int base = s - (s % n);
        return base + ((s - base + k) % n);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic chk_av(string req, int ea, bit ev);
        check(addr == ea[AW-1:0], req, addr, ea);
        check(valid == ev, req, valid, ev);
    endtask

    task automatic write_cfg(int m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m[1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // sweep one burst; R2 R3 R4 R5 R6 R7
    task automatic run_burst(int m, int s, int beats, bit stalls);
        int done = 0;
        int c = 0;
        @(negedge clk);
        start = 1'b1; start_addr = s[AW-1:0]; advance = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (done <= beats) begin
            bit adv;
            chk_av((m == 0) ? "R3" : "R4", exp_addr(m, s, done), 1'b1);
            adv = !(stalls && (c % 3 == 1));
            advance = adv;
            @(negedge clk);
            if (adv) done++;
            c++;
        end
        advance = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk_av("R1", 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_av("R1", 0, 1'b0);

        // R1 default continuous: rollover without any config write
        run_burst(0, SPAN - 1, 3, 1'b0);

        for (int m = 0; m < 4; m++) begin
            if (m != 0) write_cfg(m);
            for (int s = 0; s < SPAN; s++) begin
                run_burst(m, s, 34, (s % 8) == 3);
            end
        end

        // R6 explicit stall
        write_cfg(2);
        @(negedge clk); start = 1'b1; start_addr = 8'd30;
        @(negedge clk); start = 1'b0; advance = 1'b0;
        repeat (4) @(negedge clk);
        chk_av("R6", 30, 1'b1);
        advance = 1'b1;
        @(negedge clk);
        chk_av("R6", 31, 1'b1);
        @(negedge clk);
        chk_av("R5", 16, 1'b1);

        // R7 restart mid-burst
        advance = 1'b1; start = 1'b1; start_addr = 8'd100;
        @(negedge clk);
        start = 1'b0;
        chk_av("R7", 100, 1'b1);
        @(negedge clk);
        chk_av("R7", 101, 1'b1);

        // R8 stop freezes address, later beats ignored
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk_av("R8", 101, 1'b0);
        repeat (3) @(negedge clk);
        chk_av("R8", 101, 1'b0);
        advance = 1'b0;

        // R10 start and stop together
        start = 1'b1; stop = 1'b1; start_addr = 8'd40;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk_av("R10", 40, 1'b1);

        // R9 mode write during a burst
        write_cfg(1);
        @(negedge clk); start = 1'b1; start_addr = 8'd5;
        @(negedge clk); start = 1'b0; advance = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_av("R9", 7, 1'b1);
        cfg_we = 1'b1; cfg_mode = 2'b00;
        @(negedge clk);
        cfg_we = 1'b0;
        chk_av("R9", 0, 1'b1);
        @(negedge clk);
        chk_av("R9", 1, 1'b1);
        advance = 1'b0; start = 1'b1; start_addr = 8'd7;
        @(negedge clk);
        start = 1'b0; advance = 1'b1;
        chk_av("R9", 7, 1'b1);
        @(negedge clk);
        advance = 1'b0;
        chk_av("R9", 8, 1'b1);

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (190000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule